// File: doc/BRIEF.md
# Data-Move Instruction Decoder

This block decodes the register/memory data-move family of a 32-bit, byte-granular instruction set. Each cycle it may accept a window of up to fifteen instruction bytes together with the default operand-size and address-size attributes. One cycle later it presents the decoded result:
- the operand form and the data width;
- which side is written and the register selector;
- the addressing-byte fields;
- the displacement and immediate byte counts;
- the exact instruction length;
- a flag for an encoding it must reject.

The only prefix it honours is the operand-size override byte (66h) in the first window position. Address arithmetic, register access and execution belong to later stages. A fetch or length-marking stage uses the length to step to the next instruction, and an issue stage uses the fields to steer operands.

Window bytes are little-endian: byte 0 sits in `in_bytes[7:0]` and byte k in `in_bytes[8k+7:8k]`.

Top module: `mov_decoder`

## Requirements
- R1: `out_valid` is 0 while in reset. It is 1 in the cycle after every cycle with `in_valid` high and 0 after every cycle with `in_valid` low. All other outputs hold their previous values while `in_valid` is low.
- R2: Opcodes 88h/8Ah have width code 0 (8 bits). Opcodes 89h/8Bh have width 1 (16) or 2 (32) per the effective operand size. Form code is 1 for 88h/89h (`out_to_reg`=0) and 2 for 8Ah/8Bh (`out_to_reg`=1). The register selector is addressing-byte bits [5:3].
- R3: A 66h in byte 0 sets `out_pfx`, shifts the opcode to byte 1, adds one to the length and inverts the operand-size attribute. Byte-wide forms keep width code 0.
- R4: 8Ch (`out_to_reg`=0) and 8Eh (`out_to_reg`=1) have form code 3 and width code 1. A segment selector (bits [5:3]) above 5 is rejected, and 8Eh with selector 1 is rejected.
- R5: A0h–A3h have form code 4, no addressing byte and register selector 0. The offset count is 2 for 16-bit addressing and 4 for 32-bit addressing, independent of operand size. A0h/A1h set `out_to_reg`. Odd opcodes use the full width and even opcodes use width 0.
- R6: B0h–BFh have form code 5 and `out_to_reg`=1, with the register selector taken from opcode bits [2:0]. B0h–B7h carry a 1-byte immediate (width 0). B8h–BFh carry 2 or 4 immediate bytes per operand size.
- R7: C6h/C7h have form code 6 and an addressing byte. The immediate is 1 byte (C6h) or 2/4 bytes (C7h). A nonzero addressing-byte bits [5:3] is rejected.
- R8: With 32-bit addressing and mod (bits [7:6]) not 3:
  - rm (bits [2:0]) = 4 adds a scale-index byte;
  - mod 1 gives 1 displacement byte and mod 2 gives 4;
  - mod 0 gives 4 when rm = 5, or when rm = 4 and scale-index bits [2:0] = 5, and otherwise 0.
- R9: With 16-bit addressing there is never a scale-index byte. mod 1 gives 1 displacement byte, mod 2 gives 2, and mod 0 gives 2 only when rm = 6.
- R10: For accepted encodings, `out_len` = prefix + 1 + addressing byte + scale-index byte + displacement + immediate. Any opcode outside the family, or a rejected encoding, sets `out_invalid` and drives every other decode field and the length to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_bytes | input | 120 | Instruction window, byte 0 in the low bits |
| def_op32 | input | 1 | Default operand size is 32 bits |
| def_addr32 | input | 1 | Address size is 32 bits |
| out_valid | output | 1 | Decode result present |
| out_invalid | output | 1 | Encoding rejected |
| out_form | output | 3 | Form code (0 none, 1..6 per R2, R4–R7) |
| out_width | output | 2 | 0: 8, 1: 16, 2: 32 bits |
| out_to_reg | output | 1 | Register/accumulator side is the destination |
| out_reg | output | 3 | Register or segment selector |
| out_rm | output | 3 | Addressing-byte rm field |
| out_mod | output | 2 | Addressing-byte mod field |
| out_has_modrm | output | 1 | Addressing byte present |
| out_has_sib | output | 1 | Scale-index byte present |
| out_pfx | output | 1 | Operand-size override seen |
| out_disp_len | output | 3 | Displacement or offset bytes |
| out_imm_len | output | 3 | Immediate bytes |
| out_len | output | 4 | Total instruction length in bytes |

## Verification
The bench walks every family opcode through both operand sizes, both address sizes and with and without the override. Each opcode is paired with addressing bytes covering:
- register mode;
- the no-base 32-bit and 16-bit direct cases;
- a scale-index byte with and without the no-base encoding;
- 8-bit displacement;
- full displacement.

A design that sized the accumulator offset by operand size would give a 3-byte length where 5 is due. One that ignored the scale-index base would undercount by four. One that applied the override to byte forms would widen them. Rejected cases are also exercised, each of which a lax decoder would report as a valid decode:
- a code-segment load;
- out-of-range segment selectors;
- immediate-to-memory with a nonzero reg field;
- neighbouring non-family opcodes.

// File: rtl/mov_dec_pkg.sv
package mov_dec_pkg;

  typedef enum logic [2:0] {
    FRM_NONE     = 3'd0,
    FRM_STORE_RM = 3'd1,
    FRM_LOAD_REG = 3'd2,
    FRM_SEG      = 3'd3,
    FRM_ACC      = 3'd4,
    FRM_IMM_REG  = 3'd5,
    FRM_IMM_RM   = 3'd6
  } form_e;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } wid_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_BYTE = 2'd1,
    IMM_FULL = 2'd2
  } imm_e;

  localparam logic [7:0] OPSZ_PFX  = 8'h66;
  localparam int         CNT_W     = 3;
  localparam int         SEG_LAST  = 5;
  localparam logic [2:0] SEG_CODE  = 3'd1;

  typedef struct packed {
    form_e            form;
    wid_e             wid;
    logic             to_reg;
    logic [2:0]       rg;
    logic [2:0]       rm;
    logic [1:0]       md;
    logic             has_modrm;
    logic             has_sib;
    logic             pfx;
    logic [CNT_W-1:0] disp;
    logic [CNT_W-1:0] imm;
    logic             invalid;
  } dec_t;

endpackage

// File: rtl/mov_byte_pick.sv
module mov_byte_pick
  import mov_dec_pkg::*;
#(
  parameter  int MAX_BYTES = 15,
  localparam int WIN_W     = MAX_BYTES * 8,
  localparam int IDX_W     = $clog2(MAX_BYTES)
) (
  input  logic [WIN_W-1:0] win,
  output logic             pfx,
  output logic [7:0]       opc,
  output logic [7:0]       modrm,
  output logic [2:0]       sib_base
);

  logic [7:0]       win_b [MAX_BYTES];
  logic [IDX_W-1:0] i_op;
  logic [IDX_W-1:0] i_mr;
  logic [IDX_W-1:0] i_sb;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_split
    assign win_b[g] = win[8*g +: 8];
  end

  assign pfx      = (win_b[0] == OPSZ_PFX);
  assign i_op     = IDX_W'(pfx);
  assign i_mr     = i_op + IDX_W'(1);
  assign i_sb     = i_op + IDX_W'(2);
  assign opc      = win_b[i_op];
  assign modrm    = win_b[i_mr];
  assign sib_base = win_b[i_sb][2:0];

endmodule

// File: rtl/mov_opc_class.sv
module mov_opc_class
  import mov_dec_pkg::*;
(
  input  logic [7:0] opc,
  input  logic       op32,
  input  logic [2:0] mreg,
  output form_e      form,
  output wid_e       wid,
  output logic       to_reg,
  output logic       use_modrm,
  output imm_e       imm,
  output logic       reg_in_opc,
  output logic       bad
);

  wid_e wfull;
  assign wfull = op32 ? WID_32 : WID_16;

  always_comb begin
    form       = FRM_NONE;
    wid        = WID_8;
    to_reg     = 1'b0;
    use_modrm  = 1'b0;
    imm        = IMM_NONE;
    reg_in_opc = 1'b0;
    bad        = 1'b1;
    case (opc) inside
      8'h88, 8'h89, 8'h8A, 8'h8B: begin
        form      = opc[1] ? FRM_LOAD_REG : FRM_STORE_RM;
        wid       = opc[0] ? wfull : WID_8;
        to_reg    = opc[1];
        use_modrm = 1'b1;
        bad       = 1'b0;
      end
      8'h8C, 8'h8E: begin
        form      = FRM_SEG;
        wid       = WID_16;
        to_reg    = opc[1];
        use_modrm = 1'b1;
        bad       = (int'(mreg) > SEG_LAST) || (opc[1] && (mreg == SEG_CODE));
      end
      [8'hA0:8'hA3]: begin
        form   = FRM_ACC;
        wid    = opc[0] ? wfull : WID_8;
        to_reg = ~opc[1];
        bad    = 1'b0;
      end
      [8'hB0:8'hBF]: begin
        form       = FRM_IMM_REG;
        wid        = opc[3] ? wfull : WID_8;
        to_reg     = 1'b1;
        imm        = opc[3] ? IMM_FULL : IMM_BYTE;
        reg_in_opc = 1'b1;
        bad        = 1'b0;
      end
      8'hC6, 8'hC7: begin
        form      = FRM_IMM_RM;
        wid       = opc[0] ? wfull : WID_8;
        use_modrm = 1'b1;
        imm       = opc[0] ? IMM_FULL : IMM_BYTE;
        bad       = (mreg != 3'd0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mov_ea_len.sv
module mov_ea_len
  import mov_dec_pkg::*;
(
  input  logic             en,
  input  logic             addr32,
  input  logic [1:0]       md,
  input  logic [2:0]       rm,
  input  logic [2:0]       sib_base,
  output logic             has_sib,
  output logic [CNT_W-1:0] disp
);

  always_comb begin
    has_sib = 1'b0;
    disp    = '0;
    if (en && (md != 2'b11)) begin
      if (addr32) begin
        has_sib = (rm == 3'b100);
        case (md)
          2'b01:   disp = CNT_W'(1);
          2'b10:   disp = CNT_W'(4);
          default: begin
            if ((rm == 3'b101) || ((rm == 3'b100) && (sib_base == 3'b101)))
              disp = CNT_W'(4);
          end
        endcase
      end else begin
        case (md)
          2'b01:   disp = CNT_W'(1);
          2'b10:   disp = CNT_W'(2);
          default: begin
            if (rm == 3'b110)
              disp = CNT_W'(2);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mov_decoder.sv
module mov_decoder
  import mov_dec_pkg::*;
#(
  parameter  int MAX_BYTES = 15,
  localparam int WIN_W     = MAX_BYTES * 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIN_W-1:0] in_bytes,
  input  logic             def_op32,
  input  logic             def_addr32,
  output logic             out_valid,
  output logic             out_invalid,
  output logic [2:0]       out_form,
  output logic [1:0]       out_width,
  output logic             out_to_reg,
  output logic [2:0]       out_reg,
  output logic [2:0]       out_rm,
  output logic [1:0]       out_mod,
  output logic             out_has_modrm,
  output logic             out_has_sib,
  output logic             out_pfx,
  output logic [2:0]       out_disp_len,
  output logic [2:0]       out_imm_len,
  output logic [LEN_W-1:0] out_len
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // byte selection
  logic       pfx;
  logic [7:0] opc;
  logic [7:0] modrm;
  logic [2:0] sib_base;
  logic       eff_op32;

  mov_byte_pick #(.MAX_BYTES(MAX_BYTES)) u_pick (
    .win      (in_bytes),
    .pfx      (pfx),
    .opc      (opc),
    .modrm    (modrm),
    .sib_base (sib_base)
  );

  assign eff_op32 = def_op32 ^ pfx;

  // opcode classification
  form_e form;
  wid_e  wid;
  logic  to_reg;
  logic  use_modrm;
  imm_e  imm_k;
  logic  reg_in_opc;
  logic  bad;

  mov_opc_class u_cls (
    .opc        (opc),
    .op32       (eff_op32),
    .mreg       (modrm[5:3]),
    .form       (form),
    .wid        (wid),
    .to_reg     (to_reg),
    .use_modrm  (use_modrm),
    .imm        (imm_k),
    .reg_in_opc (reg_in_opc),
    .bad        (bad)
  );

  // addressing-byte length
  logic             ea_sib;
  logic [CNT_W-1:0] ea_disp;

  mov_ea_len u_ea (
    .en       (use_modrm),
    .addr32   (def_addr32),
    .md       (modrm[7:6]),
    .rm       (modrm[2:0]),
    .sib_base (sib_base),
    .has_sib  (ea_sib),
    .disp     (ea_disp)
  );

  // next-state assembly
  dec_t             nxt;
  logic [LEN_W-1:0] nxt_len;
  dec_t             cur;
  logic [LEN_W-1:0] cur_len;
  logic             cur_vld;

  always_comb begin
    nxt     = '0;
    nxt_len = '0;
    if (bad) begin
      nxt.invalid = 1'b1;
    end else begin
      nxt.form      = form;
      nxt.wid       = wid;
      nxt.to_reg    = to_reg;
      nxt.rg        = reg_in_opc ? opc[2:0] : (use_modrm ? modrm[5:3] : 3'd0);
      nxt.rm        = use_modrm ? modrm[2:0] : 3'd0;
      nxt.md        = use_modrm ? modrm[7:6] : 2'd0;
      nxt.has_modrm = use_modrm;
      nxt.has_sib   = ea_sib;
      nxt.pfx       = pfx;
      if (form == FRM_ACC) nxt.disp = def_addr32 ? CNT_W'(4) : CNT_W'(2);
      else                 nxt.disp = ea_disp;
      case (imm_k)
        IMM_BYTE: nxt.imm = CNT_W'(1);
        IMM_FULL: nxt.imm = eff_op32 ? CNT_W'(4) : CNT_W'(2);
        default:  nxt.imm = '0;
      endcase
      nxt_len = LEN_W'(pfx) + LEN_W'(1) + LEN_W'(use_modrm) + LEN_W'(ea_sib)
              + LEN_W'(nxt.disp) + LEN_W'(nxt.imm);
    end
  end

  // result registers, loaded only on accepted windows
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cur_vld <= 1'b0;
      cur     <= '0;
      cur_len <= '0;
    end else begin
      cur_vld <= in_valid;
      if (in_valid) begin
        cur     <= nxt;
        cur_len <= nxt_len;
      end
    end
  end

  assign out_valid     = cur_vld;
  assign out_invalid   = cur.invalid;
  assign out_form      = cur.form;
  assign out_width     = cur.wid;
  assign out_to_reg    = cur.to_reg;
  assign out_reg       = cur.rg;
  assign out_rm        = cur.rm;
  assign out_mod       = cur.md;
  assign out_has_modrm = cur.has_modrm;
  assign out_has_sib   = cur.has_sib;
  assign out_pfx       = cur.pfx;
  assign out_disp_len  = cur.disp;
  assign out_imm_len   = cur.imm;
  assign out_len       = cur_len;

endmodule

// File: rtl/mov_dec_chk.sv
module mov_dec_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_invalid,
  input logic [2:0]       out_form,
  input logic [1:0]       out_width,
  input logic [2:0]       out_reg,
  input logic [1:0]       out_mod,
  input logic             out_has_modrm,
  input logic             out_has_sib,
  input logic [2:0]       out_disp_len,
  input logic [2:0]       out_imm_len,
  input logic [LEN_W-1:0] out_len
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> (!out_valid && $stable(out_len) && $stable(out_form)));

  p_seg_word_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_form == 3'd3) |-> (out_width == 2'd1 && out_reg <= 3'd5));

  p_acc_offset_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_form == 3'd4) |-> (!out_has_modrm && out_reg == 3'd0 &&
                            (out_disp_len == 3'd2 || out_disp_len == 3'd4)));

  p_byte_imm_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_form == 3'd5 && out_width == 2'd0) |-> (out_imm_len == 3'd1));

  p_imm_rm_reg0_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_form == 3'd6) |-> (out_reg == 3'd0 && out_imm_len != 3'd0 && out_has_modrm));

  p_sib_needs_mem_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_has_sib |-> (out_has_modrm && out_mod != 2'b11));

  p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && out_invalid) |-> (out_len == '0 && out_form == 3'd0));

endmodule

bind mov_decoder mov_dec_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_invalid   (out_invalid),
  .out_form      (out_form),
  .out_width     (out_width),
  .out_reg       (out_reg),
  .out_mod       (out_mod),
  .out_has_modrm (out_has_modrm),
  .out_has_sib   (out_has_sib),
  .out_disp_len  (out_disp_len),
  .out_imm_len   (out_imm_len),
  .out_len       (out_len)
);

// File: tb/mov_decoder_tb.sv
module mov_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_BYTES  = 15;
  localparam int WIN_W      = MAX_BYTES * 8;
  localparam int WD_CYCLES  = 100000;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [WIN_W-1:0] in_bytes;
  logic             def_op32;
  logic             def_addr32;
  logic             out_valid;
  logic             out_invalid;
  logic [2:0]       out_form;
  logic [1:0]       out_width;
  logic             out_to_reg;
  logic [2:0]       out_reg;
  logic [2:0]       out_rm;
  logic [1:0]       out_mod;
  logic             out_has_modrm;
  logic             out_has_sib;
  logic             out_pfx;
  logic [2:0]       out_disp_len;
  logic [2:0]       out_imm_len;
  logic [3:0]       out_len;

  mov_decoder #(.MAX_BYTES(MAX_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .def_op32(def_op32), .def_addr32(def_addr32), .out_valid(out_valid),
    .out_invalid(out_invalid), .out_form(out_form), .out_width(out_width),
    .out_to_reg(out_to_reg), .out_reg(out_reg), .out_rm(out_rm), .out_mod(out_mod),
    .out_has_modrm(out_has_modrm), .out_has_sib(out_has_sib), .out_pfx(out_pfx),
    .out_disp_len(out_disp_len), .out_imm_len(out_imm_len), .out_len(out_len)
  );

  typedef struct {
    logic [2:0] form;
    logic [1:0] wid;
    logic       to_reg;
    logic [2:0] rg;
    logic [2:0] rm;
    logic [1:0] md;
    logic       hm;
    logic       hs;
    logic       pf;
    logic [2:0] dl;
    logic [2:0] il;
    logic [3:0] len;
    logic       inv;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  bit   run = 0;
  int   total = 0;
  int   bad = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference decode, written from the requirement list
  function automatic exp_t model(input logic [7:0] b0, b1, b2, b3,
                                 input logic o32, a32);
    exp_t       e;
    logic [7:0] op, m, s;
    logic       eo, need_m;
    string      t;
    e.form = 0; e.wid = 0; e.to_reg = 0; e.rg = 0; e.rm = 0; e.md = 0;
    e.hm = 0; e.hs = 0; e.dl = 0; e.il = 0; e.inv = 0;
    e.pf   = (b0 == 8'h66);                  // R3
    op     = e.pf ? b1 : b0;
    m      = e.pf ? b2 : b1;
    s      = e.pf ? b3 : b2;
    eo     = o32 ^ e.pf;
    need_m = 0;
    t      = "";
    if (op == 8'h88 || op == 8'h89 || op == 8'h8A || op == 8'h8B) begin
      e.form = op[1] ? 3'd2 : 3'd1; e.wid = op[0] ? (eo ? 2'd2 : 2'd1) : 2'd0;
      e.to_reg = op[1]; need_m = 1; e.rg = m[5:3]; t = "R2";
    end else if (op == 8'h8C || op == 8'h8E) begin
      e.form = 3'd3; e.wid = 2'd1; e.to_reg = (op == 8'h8E); need_m = 1; e.rg = m[5:3];
      e.inv = (m[5:3] > 3'd5) || (op == 8'h8E && m[5:3] == 3'd1); t = "R4";
    end else if (op >= 8'hA0 && op <= 8'hA3) begin
      e.form = 3'd4; e.wid = op[0] ? (eo ? 2'd2 : 2'd1) : 2'd0;
      e.to_reg = !op[1]; e.dl = a32 ? 3'd4 : 3'd2; t = "R5";
    end else if (op >= 8'hB0 && op <= 8'hBF) begin
      e.form = 3'd5; e.wid = op[3] ? (eo ? 2'd2 : 2'd1) : 2'd0; e.to_reg = 1;
      e.rg = op[2:0]; e.il = op[3] ? (eo ? 3'd4 : 3'd2) : 3'd1; t = "R6";
    end else if (op == 8'hC6 || op == 8'hC7) begin
      e.form = 3'd6; e.wid = op[0] ? (eo ? 2'd2 : 2'd1) : 2'd0; need_m = 1;
      e.rg = m[5:3]; e.il = op[0] ? (eo ? 3'd4 : 3'd2) : 3'd1;
      e.inv = (m[5:3] != 3'd0); t = "R7";
    end else begin
      e.inv = 1; t = "outside";
    end
    if (need_m) begin
      e.hm = 1; e.md = m[7:6]; e.rm = m[2:0];
      if (m[7:6] != 2'b11) begin
        if (a32) begin
          e.hs = (m[2:0] == 3'd4);
          if (m[7:6] == 2'b01)      e.dl = 3'd1;
          else if (m[7:6] == 2'b10) e.dl = 3'd4;
          else if (m[2:0] == 3'd5 || (m[2:0] == 3'd4 && s[2:0] == 3'd5)) e.dl = 3'd4;
          t = {t, " R8"};
        end else begin
          if (m[7:6] == 2'b01)      e.dl = 3'd1;
          else if (m[7:6] == 2'b10) e.dl = 3'd2;
          else if (m[2:0] == 3'd6)  e.dl = 3'd2;
          t = {t, " R9"};
        end
      end
    end
    if (e.pf) t = {t, " R3"};
    e.len = 4'(e.pf) + 4'd1 + 4'(e.hm) + 4'(e.hs) + 4'(e.dl) + 4'(e.il);
    if (e.inv) begin
      e.form = 0; e.wid = 0; e.to_reg = 0; e.rg = 0; e.rm = 0; e.md = 0;
      e.hm = 0; e.hs = 0; e.pf = 0; e.dl = 0; e.il = 0; e.len = 0;
    end
    e.tag = {t, " R10"};
    return e;
  endfunction

  function automatic logic [27:0] pack_exp(input exp_t e);
    return {e.form, e.wid, e.to_reg, e.rg, e.rm, e.md, e.hm, e.hs, e.pf,
            e.dl, e.il, e.len, e.inv};
  endfunction

  function automatic logic [27:0] pack_act();
    return {out_form, out_width, out_to_reg, out_reg, out_rm, out_mod, out_has_modrm,
            out_has_sib, out_pfx, out_disp_len, out_imm_len, out_len, out_invalid};
  endfunction

  // driver: called at a falling edge, leaves at the next falling edge
  task automatic send(input logic [7:0] b0, b1, b2, b3, input logic o32, a32);
    q.push_back(model(b0, b1, b2, b3, o32, a32));
    in_bytes   = {{(MAX_BYTES - 4){8'hEE}}, b3, b2, b1, b0};
    def_op32   = o32;
    def_addr32 = a32;
    in_valid   = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_bytes = {MAX_BYTES{8'h90}};
    @(negedge clk);
  endtask

  task automatic send_op(input logic [7:0] op, input logic [15:0] ms,
                         input logic pf, input logic o32, a32);
    if (pf) send(8'h66, op, ms[15:8], ms[7:0], o32, a32);
    else    send(op, ms[15:8], ms[7:0], 8'hEE, o32, a32);
  endtask

  // monitor: compares each result against the oldest expectation
  always @(negedge clk) begin
    if (run) begin
      if (out_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected result actual=%h expected=none", pack_act());
        end else begin
          exp_t e;
          e = q.pop_front();
          if (pack_act() !== pack_exp(e)) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", e.tag, pack_act(), pack_exp(e));
          end
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        total++;                             // R1: fields held while idle
        if (pack_act() !== pack_exp(last)) begin
          bad++;
          $display("FAIL R1 hold actual=%h expected=%h", pack_act(), pack_exp(last));
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0]  fam [28];
  logic [15:0] mvar [11];

  initial begin
    int n;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_bytes   = '0;
    def_op32   = 1'b0;
    def_addr32 = 1'b0;
    for (int i = 0; i < 6; i++) fam[i] = 8'h00;
    fam[0] = 8'h88; fam[1] = 8'h89; fam[2] = 8'h8A; fam[3] = 8'h8B;
    fam[4] = 8'h8C; fam[5] = 8'h8E;
    for (int i = 0; i < 4; i++)  fam[6 + i]  = 8'hA0 + 8'(i);
    for (int i = 0; i < 16; i++) fam[10 + i] = 8'hB0 + 8'(i);
    fam[26] = 8'hC6; fam[27] = 8'hC7;
    // addressing byte (high) and scale-index byte (low)
    mvar[0] = 16'hC1_00; mvar[1]  = 16'hD8_00; mvar[2] = 16'h05_00;
    mvar[3] = 16'h06_00; mvar[4]  = 16'h44_00; mvar[5] = 16'h04_25;
    mvar[6] = 16'h04_20; mvar[7]  = 16'h86_00; mvar[8] = 16'hC8_00;
    mvar[9] = 16'hF0_00; mvar[10] = 16'h08_00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;                                 // R1: reset state
    if (out_valid !== 1'b0 || out_len !== 4'd0 || out_invalid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%h expected=0/0", out_valid, out_len);
    end
    run = 1;

    n = 0;
    for (int a = 0; a < 2; a++) begin
      for (int o = 0; o < 2; o++) begin
        for (int p = 0; p < 2; p++) begin
          for (int f = 0; f < 28; f++) begin
            for (int v = 0; v < 11; v++) begin
              send_op(fam[f], mvar[v], 1'(p), 1'(o), 1'(a));
              n++;
              if (n % 7 == 0) idle();
            end
          end
        end
      end
    end
    // R10: neighbours outside the family, and a doubled override byte
    send(8'h8D, 8'h05, 8'h00, 8'h00, 1'b1, 1'b1);
    send(8'h8F, 8'hC0, 8'h00, 8'h00, 1'b0, 1'b0);
    send(8'hA4, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    send(8'hC5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    send(8'h67, 8'hA1, 8'h00, 8'h00, 1'b1, 1'b1);
    send(8'h66, 8'h66, 8'hB8, 8'h00, 1'b1, 1'b1);
    idle();
    // R5: accumulator offset follows address size, not operand size
    send(8'hA1, 8'h11, 8'h22, 8'h33, 1'b1, 1'b0);
    send(8'h66, 8'hA3, 8'h11, 8'h22, 1'b0, 1'b1);
    idle();
    idle();
    idle();
    run = 0;
    total++;                                 // R1: every input produced a result
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1 pending actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule